// File: doc/BRIEF.md
# Semi-Broadcast Weight-Stationary MAC Array

This block is an 8 by 8 grid of signed integer multiply-accumulate cells that computes one row of a matrix product per clock. Each cell keeps one weight for the whole run. The caller loads these weights one cell row at a time. The caller then streams rows of the left operand, and each row comes with a vector of accumulator seeds. The element that belongs to a given column goes to every cell of that column in the same cycle. Only the partial sums move from cell to cell, one column to the right per clock.

The caller presents a whole operand row at once. Internal delay lines skew each column's element by its column index, so the element meets the partial sum that is passing through that column. The left operand may have any height. Rows may be sent back to back, or with idle cycles between them. Each finished output vector leaves the right edge together with a valid flag that travels through the array alongside the data.

Top module: `sbws_array`

## Requirements
- R1: After a synchronous reset, `out_valid` is low. All weights are zero, so until a load takes place each output lane equals its seed.
- R2: A cycle with `load_w` high writes lane k of `w_data` (bits 16k+15..16k) into the cell at row `w_sel`, column k. That cell then holds element B[k][w_sel] of the stationary operand.
- R3: For an operand row a sampled with seeds c, output lane r (bits 32r+31..32r of `out_data`) equals c[r] + sum over k of a[k]*B[k][r]. Lane k of `a_row` is bits 16k+15..16k, and lane r of `c_in` is bits 32r+31..32r.
- R4: `out_valid` goes high exactly 8 rising edges after the edge that samples `in_valid` high, counting that edge as the first. Rows leave in the order they were given.
- R5: Rows accepted on consecutive cycles produce results on consecutive cycles. This holds for any operand height from 1 to 32.
- R6: Operands are 16-bit two's complement and accumulation is 32-bit. A sum that overflows wraps modulo 2^32.
- R7: Idle input cycles produce cycles with `out_valid` low at the matching output positions.
- R8: While `load_w` is low, changes on `w_data` and `w_sel` leave the stored weights untouched.
- R9: A weight reload done after a stream has drained applies to every row sent later. A load must not be issued while a row is in flight, nor in the cycle that sends a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_w | input | 1 | Weight write strobe |
| w_sel | input | 3 | Cell row written by the strobe |
| w_data | input | 128 | Eight 16-bit weights, one per column |
| in_valid | input | 1 | Marks `a_row` and `c_in` as a row to process |
| a_row | input | 128 | Eight 16-bit signed operand elements, one per column |
| c_in | input | 256 | Eight 32-bit signed seeds, one per cell row |
| out_valid | output | 1 | Marks `out_data` as a finished row |
| out_data | output | 256 | Eight 32-bit results, one per cell row |

## Verification
A weight held in the wrong cell damages only the output lanes whose cell row holds it. The error shows on the first valid result after that weight is used. A skew line of the wrong depth pairs an element with a partial sum from the wrong row. That shows only when consecutive rows differ, so back-to-back streams with random data expose it within eight cycles. A broken valid chain moves or drops the flag, and the cycle-by-cycle comparison catches this at the very next edge where the flag is expected.

// File: rtl/sbws_pkg.sv
package sbws_pkg;
  localparam int unsigned DEF_ROWS = 8;
  localparam int unsigned DEF_COLS = 8;
  localparam int unsigned DEF_AW   = 16;
  localparam int unsigned DEF_CW   = 32;
endpackage

// File: rtl/sbws_wbuf.sv
// Stationary weight store: one row of cells written per strobe.
module sbws_wbuf #(
  parameter int unsigned ROWS = 8,
  parameter int unsigned COLS = 8,
  parameter int unsigned AW   = 16,
  localparam int unsigned SELW = $clog2(ROWS),
  localparam int unsigned RW   = COLS * AW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [SELW-1:0]      sel,
  input  logic [RW-1:0]        wdata,
  output logic [ROWS*RW-1:0]   wflat
);
  logic [RW-1:0] wrow [ROWS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++) wrow[r] <= '0;
    end else if (we) begin
      wrow[sel] <= wdata;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_out
    assign wflat[r*RW +: RW] = wrow[r];
  end
endmodule

// File: rtl/sbws_skew.sv
// Delays column k of the operand row by k cycles so it meets its partial sum.
module sbws_skew #(
  parameter int unsigned COLS = 8,
  parameter int unsigned AW   = 16
) (
  input  logic              clk,
  input  logic [COLS*AW-1:0] a_row,
  output logic [COLS*AW-1:0] a_col
);
  for (genvar k = 0; k < COLS; k++) begin : g_col
    if (k == 0) begin : g_direct
      assign a_col[AW-1:0] = a_row[AW-1:0];
    end else begin : g_delay
      logic [AW-1:0] dl [k];
      always_ff @(posedge clk) begin
        dl[0] <= a_row[k*AW +: AW];
        for (int j = 1; j < k; j++) dl[j] <= dl[j-1];
      end
      assign a_col[k*AW +: AW] = dl[k-1];
    end
  end
endmodule

// File: rtl/sbws_pe.sv
// One cell: registered partial sum = incoming sum + broadcast element * weight.
module sbws_pe #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] w,
  input  logic [CW-1:0] ps_in,
  output logic [CW-1:0] ps_out
);
  localparam int unsigned PW = 2 * AW;
  logic signed [PW-1:0] prod;
  logic signed [CW-1:0] prod_x;

  always_comb begin
    prod   = $signed(a) * $signed(w);
    prod_x = CW'(prod);
  end

  always_ff @(posedge clk) begin
    ps_out <= ps_in + prod_x;
  end
endmodule

// File: rtl/sbws_array.sv
module sbws_array
  import sbws_pkg::*;
#(
  parameter int unsigned ROWS = DEF_ROWS,
  parameter int unsigned COLS = DEF_COLS,
  parameter int unsigned AW   = DEF_AW,
  parameter int unsigned CW   = DEF_CW
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load_w,
  input  logic [$clog2(ROWS)-1:0]    w_sel,
  input  logic [COLS*AW-1:0]         w_data,
  input  logic                       in_valid,
  input  logic [COLS*AW-1:0]         a_row,
  input  logic [ROWS*CW-1:0]         c_in,
  output logic                       out_valid,
  output logic [ROWS*CW-1:0]         out_data
);
  localparam int unsigned RW = COLS * AW;

  logic [ROWS*RW-1:0] wflat;
  logic [COLS*AW-1:0] a_col;
  logic [CW-1:0]      ps [ROWS][COLS+1];
  logic [COLS-1:0]    vld_q;

  sbws_wbuf #(.ROWS(ROWS), .COLS(COLS), .AW(AW)) u_wbuf (
    .clk(clk), .rst(rst), .we(load_w), .sel(w_sel), .wdata(w_data), .wflat(wflat)
  );

  sbws_skew #(.COLS(COLS), .AW(AW)) u_skew (
    .clk(clk), .a_row(a_row), .a_col(a_col)
  );

  // valid tag travels one column per cycle beside the partial sums
  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= {vld_q[COLS-2:0], in_valid};
  end
  assign out_valid = vld_q[COLS-1];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign ps[r][0] = c_in[r*CW +: CW];
    for (genvar k = 0; k < COLS; k++) begin : g_cell
      sbws_pe #(.AW(AW), .CW(CW)) u_pe (
        .clk   (clk),
        .a     (a_col[k*AW +: AW]),
        .w     (wflat[(r*COLS+k)*AW +: AW]),
        .ps_in (ps[r][k]),
        .ps_out(ps[r][k+1])
      );
    end
    assign out_data[r*CW +: CW] = ps[r][COLS];
  end
endmodule

// File: rtl/sbws_array_chk.sv
module sbws_array_chk #(
  parameter int unsigned ROWS = 8,
  parameter int unsigned COLS = 8,
  parameter int unsigned CW   = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               load_w,
  input logic               in_valid,
  input logic               out_valid,
  input logic [ROWS*CW-1:0] out_data
);
  logic [COLS-1:0] hist;
  logic            rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) hist <= '0;
    else     hist <= {hist[COLS-2:0], in_valid};
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> !out_valid);

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == hist[COLS-1]);

  // R9
  load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    load_w |-> (!in_valid && hist[COLS-2:0] == '0));

  // R3
  data_known_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !$isunknown(out_data));
endmodule

bind sbws_array sbws_array_chk #(.ROWS(ROWS), .COLS(COLS), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .load_w(load_w), .in_valid(in_valid),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/sbws_array_bench.sv
module sbws_array_bench;
  localparam int R = 8, C = 8, AW = 16, CW = 32;

  logic clk = 1'b0, rst = 1'b1, load_w = 1'b0, in_valid = 1'b0;
  logic [2:0]      w_sel = '0;
  logic [C*AW-1:0] w_data = '0, a_row = '0;
  logic [R*CW-1:0] c_in = '0;
  logic            out_valid;
  logic [R*CW-1:0] out_data;

  sbws_array u_sbws_array (
    .clk(clk), .rst(rst), .load_w(load_w), .w_sel(w_sel), .w_data(w_data),
    .in_valid(in_valid), .a_row(a_row), .c_in(c_in),
    .out_valid(out_valid), .out_data(out_data)
  );

  always #2 clk = ~clk;  // 250 MHz

  int cyc = 0, total = 0, bad = 0;
  bit done = 0;
  string tag = "R1";
  int ref_w [R][C];
  int due_q [$];
  logic [R*CW-1:0] exp_q [$];
  logic [R*CW-1:0] exp_v;
  bit want;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [R*CW-1:0] model(logic [C*AW-1:0] a, logic [R*CW-1:0] c);
    logic [R*CW-1:0] res;
    for (int r = 0; r < R; r++) begin
      int acc;
      acc = int'($signed(c[r*CW +: CW]));
      for (int k = 0; k < C; k++) acc += int'($signed(a[k*AW +: AW])) * ref_w[r][k];
      res[r*CW +: CW] = acc;
    end
    return res;
  endfunction

  // cycle-by-cycle comparison against the queued reference results
  always @(negedge clk) begin
    if (!rst && !done) begin
      want = (due_q.size() > 0 && due_q[0] == cyc);
      total++;
      if (out_valid !== want) begin
        bad++;
        $display("FAIL R4 cycle %0d out_valid actual=%b expected=%b", cyc, out_valid, want);
      end
      if (want) begin
        exp_v = exp_q.pop_front();
        void'(due_q.pop_front());
        total++;
        if (out_data !== exp_v) begin
          bad++;
          $display("FAIL %s cycle %0d out_data actual=%h expected=%h", tag, cyc, out_data, exp_v);
        end
      end
    end
  end

  task automatic idle(int n, bit wiggle);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      load_w = 0; in_valid = 0;
      if (wiggle) begin  // R8: weight inputs move without the strobe
        w_data = {$urandom, $urandom, $urandom, $urandom};
        w_sel  = 3'($urandom);
      end
    end
  endtask

  task automatic load_row(int r, logic [C*AW-1:0] wv);
    @(negedge clk);
    in_valid = 0; load_w = 1; w_sel = 3'(r); w_data = wv;
    for (int k = 0; k < C; k++) ref_w[r][k] = int'($signed(wv[k*AW +: AW]));
  endtask

  task automatic load_random(int span);
    for (int r = 0; r < R; r++) begin
      logic [C*AW-1:0] wv;
      for (int k = 0; k < C; k++) wv[k*AW +: AW] = AW'($urandom_range(2*span) - span);
      load_row(r, wv);
    end
    idle(2, 0);
  endtask

  task automatic send(logic [C*AW-1:0] a, logic [R*CW-1:0] c);
    @(negedge clk);
    load_w = 0; in_valid = 1; a_row = a; c_in = c;
    due_q.push_back(cyc + 8);
    exp_q.push_back(model(a, c));
  endtask

  task automatic stream(int m, int gap_pct);
    for (int i = 0; i < m; i++) begin
      logic [C*AW-1:0] a;
      logic [R*CW-1:0] c;
      if (gap_pct > 0 && $urandom_range(99) < gap_pct) idle(1, 0);
      for (int k = 0; k < C; k++) a[k*AW +: AW] = AW'($urandom);
      for (int r = 0; r < R; r++) c[r*CW +: CW] = $urandom;
      send(a, c);
    end
    idle(12, 0);
  endtask

  initial begin
    for (int r = 0; r < R; r++) for (int k = 0; k < C; k++) ref_w[r][k] = 0;
    repeat (3) @(negedge clk);
    total++;  // R1: flag low while reset is held
    if (out_valid !== 1'b0) begin
      bad++; $display("FAIL R1 out_valid in reset actual=%b expected=0", out_valid);
    end
    rst = 0;
    idle(4, 0);
    tag = "R1"; stream(3, 0);              // zero weights pass seeds through
    tag = "R2"; load_random(300); stream(6, 0);
    tag = "R3"; load_random(32767);
    for (int t = 0; t < 6; t++) stream($urandom_range(1, 32), 0);
    tag = "R5"; stream(1, 0); stream(32, 0);
    tag = "R7"; stream(24, 40);
    tag = "R6";
    for (int r = 0; r < R; r++) load_row(r, {C{16'sh8000}});
    idle(2, 0);
    send({C{16'sh8000}}, {R{32'h7fff_ffff}});
    send({C{16'sh7fff}}, {R{32'h8000_0000}});
    idle(12, 0);
    tag = "R8"; idle(20, 1); stream(8, 0);
    tag = "R9"; load_random(1000); stream(10, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL R5 watchdog actual=cycle %0d expected=finish before limit", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule